// File: doc/BRIEF.md
# Dual-Bank Flash Command Controller

This block sits between a processor bus and two independent flash banks, a main bank and a smaller secondary bank. Writes to a bank are not stored as data. They are decoded as multi-write unlock and command sequences that start a byte program, an erase of selected sectors, or an erase of the whole bank. While a bank is busy, reads from it return a status byte. That byte carries an inverted polling bit, a bit that toggles on every read, and an error bit. A ready output tells the system when no operation is running.

Each bank has its own decoder, operation timer and storage, so one bank can be read or given commands while the other is busy. An erase can be suspended so that other sectors can be read, then resumed. Sectors can be protected through input masks. A warm reset aborts any operation in progress. The storage is a small behavioural array: sectors hold 2^BYTE_AW bytes, and operations take a fixed, parameterised number of cycles.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A command starts with write AAh at offset 555h and then write 55h at offset AAAh, where the offset is bus_addr[11:0]. A write with any other value or offset during an unlock or setup step sends the bank back to read mode. No operation starts and the array is unchanged.
- R2: Unlock, then A0h at 555h, then a data byte at the target address, programs that byte. The bank stays busy for PROG_CYC cycles, and the byte then holds old AND data.
- R3: A program that would turn a 0 bit into 1 leaves the byte unchanged. After the busy time, status reads return bit 5 = 1 until a write of F0h to any address in that bank returns it to read mode.
- R4: Unlock, 80h at 555h, unlock, then 30h at an address opens a sector-erase window of WIN_CYC cycles. Each further 30h inside the window adds its sector and reopens the window. When the window closes, the erase runs for ERASE_CYC cycles and every chosen sector then reads FFh. The sector index is the address bits just above the BYTE_AW-bit byte offset.
- R5: Unlock, 80h at 555h, unlock, then 10h at 555h erases every unprotected sector of the bank.
- R6: While a bank is in its erase window, programming, erasing or failed, reads from it return a status byte: bit 7 = inverted bit 7 of the target data (0 for erase), bit 6 toggles on every status read, bit 5 = error, bits 4..0 = 0.
- R7: rdy is 0 while either bank is in an erase window, programming or erasing. Otherwise it is 1, including when a bank is suspended or failed.
- R8: While one bank is busy, the other bank returns array data on reads and accepts its own commands.
- R9: A program aimed at a protected sector returns the bank to read mode without going busy. Protected sectors are left out of an erase, and an erase with no sector left does not start. Protection is given by wp_main and wp_sec, with bit n for sector n.
- R10: During an erase, only B0h (suspend) and F0h (abort, with the array unchanged) have any effect. All other writes are ignored.
- R11: While an erase is suspended, the timer holds and rdy is 1. Reads of sectors outside the erase set return data, and reads of sectors inside it return status. A write of 30h resumes the erase for its remaining cycles.
- R12: A warm_rst pulse aborts any operation in either bank and returns both to read mode. The array keeps its contents.
- R13: A read returns bus_rdata on the clock after bus_re and holds it until the next read. After power-on reset, every byte reads FFh, rdy is 1 and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; erases the array |
| warm_rst | input | 1 | Synchronous abort of all operations |
| bus_we | input | 1 | Write strobe (command byte) |
| bus_re | input | 1 | Read strobe |
| bus_bank | input | 1 | Bank select: 0 main, 1 secondary |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | 8 | Write data |
| wp_main | input | MAIN_SECTORS | Main bank sector protect mask |
| wp_sec | input | SEC_SECTORS | Secondary bank sector protect mask |
| bus_rdata | output | 8 | Read data or status, registered |
| rdy | output | 1 | High when no operation is running |

## Verification
The bench runs unlock sequences that are correct and sequences that go wrong at the first, second and third step. This separates an aborted decode from one that starts an operation. Programs that only clear bits are tried against programs that try to set bits, which separates committed data from the error state. Single-sector, multi-sector and whole-bank erases are run with and without protected sectors, and with a suspend, an ignored write, a resume and an abort in the middle. These show the order of the timer and of the erase set. Commands sent to one bank while the other is busy, plus a warm reset during a program, show that the two banks are independent and that the abort works.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
   typedef enum logic [3:0] {
      S_READ, S_UNL1, S_UNL2, S_PGM_ARM,
      S_ER_SET, S_ER_UNL1, S_ER_UNL2, S_ER_WIN,
      S_BUSY_PGM, S_BUSY_ER, S_SUSP, S_FAIL
   } fsm_t;

   localparam logic [11:0] OFS_A = 12'h555;
   localparam logic [11:0] OFS_B = 12'hAAA;

   localparam logic [7:0] K_UNL1  = 8'hAA;
   localparam logic [7:0] K_UNL2  = 8'h55;
   localparam logic [7:0] K_PGM   = 8'hA0;
   localparam logic [7:0] K_ERSET = 8'h80;
   localparam logic [7:0] K_BULK  = 8'h10;
   localparam logic [7:0] K_SECT  = 8'h30;
   localparam logic [7:0] K_SUSP  = 8'hB0;
   localparam logic [7:0] K_RST   = 8'hF0;
endpackage

// File: rtl/flash_store.sv
module flash_store #(
   parameter int SECTORS = 8,
   parameter int BYTE_AW = 4,
   localparam int SW     = $clog2(SECTORS),
   localparam int AW     = BYTE_AW + SW,
   localparam int BYTES  = 1 << BYTE_AW,
   localparam int DEPTH  = SECTORS * BYTES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      rd_addr,
   output logic [7:0]         rd_data,
   input  logic               pg_en,
   input  logic [AW-1:0]      pg_addr,
   input  logic [7:0]         pg_data,
   input  logic               er_en,
   input  logic [SECTORS-1:0] er_mask
);
   if (SECTORS < 2 || (1 << SW) != SECTORS) begin : g_chk_sect
      $error("flash_store: SECTORS must be a power of two, at least 2");
   end

   logic [7:0] mem [DEPTH];

   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else begin
         if (er_en) begin
            for (int s = 0; s < SECTORS; s++)
               if (er_mask[s])
                  for (int k = 0; k < BYTES; k++) mem[s*BYTES + k] <= 8'hFF;
         end
         if (pg_en) mem[pg_addr] <= mem[pg_addr] & pg_data;
      end
   end

   for (genvar s = 0; s < SECTORS; s++) begin : g_er_chk
      // R4: a sector in the erase set reads erased after the commit edge
      a_r4_sector_erased: assert property (@(posedge clk) disable iff (!rst_n)
         (er_en && er_mask[s]) |=> (mem[s*BYTES] == 8'hFF));
   end
endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
   import flash_cmd_pkg::*;
#(
   parameter int SECTORS   = 8,
   parameter int BYTE_AW   = 4,
   parameter int ADDR_W    = 12,
   parameter int PROG_CYC  = 8,
   parameter int ERASE_CYC = 64,
   parameter int WIN_CYC   = 16,
   localparam int SW       = $clog2(SECTORS),
   localparam int AW       = BYTE_AW + SW,
   localparam int MAXC     = (ERASE_CYC > PROG_CYC) ?
                             ((ERASE_CYC > WIN_CYC) ? ERASE_CYC : WIN_CYC) :
                             ((PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC),
   localparam int CW       = $clog2(MAXC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               warm_rst,
   input  logic               we,
   input  logic               re,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [7:0]         wdata,
   input  logic [SECTORS-1:0] wp,
   output logic               busy,
   output logic [7:0]         rdata,
   output logic [AW-1:0]      st_addr,
   input  logic [7:0]         st_rdata,
   output logic               pg_en,
   output logic [AW-1:0]      pg_addr,
   output logic [7:0]         pg_data,
   output logic               er_en,
   output logic [SECTORS-1:0] er_mask
);
   if (PROG_CYC < 1 || ERASE_CYC < 1 || WIN_CYC < 1) begin : g_chk_cyc
      $error("flash_bank_seq: cycle counts must be at least 1");
   end

   localparam logic [CW-1:0] PROG_LD = CW'(PROG_CYC - 1);
   localparam logic [CW-1:0] ER_LD   = CW'(ERASE_CYC - 1);
   localparam logic [CW-1:0] WIN_LD  = CW'(WIN_CYC - 1);

   fsm_t               state;
   logic [CW-1:0]      cnt;
   logic [SECTORS-1:0] mask_q;
   logic [AW-1:0]      tgt_addr;
   logic [7:0]         tgt_data;
   logic               fail_q;
   logic               tog;

   logic [SW-1:0] sect;
   logic          hit_a, hit_b, prot_hit, rd_status, cmd_susp, cmd_rst;

   assign sect      = addr[BYTE_AW +: SW];
   assign hit_a     = (addr[11:0] == OFS_A);
   assign hit_b     = (addr[11:0] == OFS_B);
   assign prot_hit  = wp[sect];
   assign cmd_susp  = we && (wdata == K_SUSP);
   assign cmd_rst   = we && (wdata == K_RST);
   assign rd_status = (state inside {S_ER_WIN, S_BUSY_PGM, S_BUSY_ER, S_FAIL}) ||
                      ((state == S_SUSP) && mask_q[sect]);

   assign st_addr = addr[AW-1:0];
   assign pg_addr = tgt_addr;
   assign pg_data = tgt_data;
   assign er_mask = mask_q;
   assign busy    = state inside {S_ER_WIN, S_BUSY_PGM, S_BUSY_ER};
   assign pg_en   = !warm_rst && (state == S_BUSY_PGM) && (cnt == '0) && !fail_q;
   assign er_en   = !warm_rst && (state == S_BUSY_ER) && (cnt == '0) &&
                    !cmd_susp && !cmd_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_READ;
         cnt      <= '0;
         mask_q   <= '0;
         tgt_addr <= '0;
         tgt_data <= '0;
         fail_q   <= 1'b0;
         tog      <= 1'b0;
         rdata    <= '0;
      end else if (warm_rst) begin
         state  <= S_READ;
         cnt    <= '0;
         mask_q <= '0;
         tog    <= 1'b0;
      end else begin
         if (re) begin
            if (rd_status) begin
               rdata <= {~tgt_data[7], tog, state == S_FAIL, 5'b0};
               tog   <= ~tog;
            end else begin
               rdata <= st_rdata;
            end
         end
         unique case (state)
            S_READ:    if (we && wdata == K_UNL1 && hit_a) state <= S_UNL1;
            S_UNL1:    if (we) state <= (wdata == K_UNL2 && hit_b) ? S_UNL2 : S_READ;
            S_UNL2:    if (we) state <= (hit_a && wdata == K_PGM)   ? S_PGM_ARM :
                                        (hit_a && wdata == K_ERSET) ? S_ER_SET  : S_READ;
            S_PGM_ARM: if (we) begin
               if (prot_hit) state <= S_READ;
               else begin
                  tgt_addr <= addr[AW-1:0];
                  tgt_data <= wdata;
                  fail_q   <= |(wdata & ~st_rdata);
                  cnt      <= PROG_LD;
                  state    <= S_BUSY_PGM;
               end
            end
            S_ER_SET:  if (we) state <= (wdata == K_UNL1 && hit_a) ? S_ER_UNL1 : S_READ;
            S_ER_UNL1: if (we) state <= (wdata == K_UNL2 && hit_b) ? S_ER_UNL2 : S_READ;
            S_ER_UNL2: if (we) begin
               if (hit_a && wdata == K_BULK) begin
                  if (~wp == '0) state <= S_READ;
                  else begin
                     mask_q   <= ~wp;
                     tgt_data <= 8'hFF;
                     cnt      <= ER_LD;
                     state    <= S_BUSY_ER;
                  end
               end else if (wdata == K_SECT) begin
                  mask_q       <= '0;
                  mask_q[sect] <= !prot_hit;
                  tgt_data     <= 8'hFF;
                  cnt          <= WIN_LD;
                  state        <= S_ER_WIN;
               end else state <= S_READ;
            end
            S_ER_WIN: begin
               if (we) begin
                  if (wdata == K_SECT) begin
                     if (!prot_hit) mask_q[sect] <= 1'b1;
                     cnt <= WIN_LD;
                  end else begin
                     mask_q <= '0;
                     state  <= S_READ;
                  end
               end else if (cnt == '0) begin
                  if (mask_q == '0) state <= S_READ;
                  else begin
                     cnt   <= ER_LD;
                     state <= S_BUSY_ER;
                  end
               end else cnt <= cnt - 1'b1;
            end
            S_BUSY_PGM: begin
               if (cnt == '0) state <= fail_q ? S_FAIL : S_READ;
               else cnt <= cnt - 1'b1;
            end
            S_BUSY_ER: begin
               if (cmd_susp) state <= S_SUSP;
               else if (cmd_rst || cnt == '0) begin
                  mask_q <= '0;
                  state  <= S_READ;
               end else cnt <= cnt - 1'b1;
            end
            S_SUSP: begin
               if (we && wdata == K_SECT) state <= S_BUSY_ER;
               else if (cmd_rst) begin
                  mask_q <= '0;
                  state  <= S_READ;
               end
            end
            S_FAIL:    if (cmd_rst) state <= S_READ;
            default:   state <= S_READ;
         endcase
      end
   end

   // R12: warm reset always lands in read mode
   a_r12_warm_abort: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst |=> (state == S_READ));

   // R10: a running erase is not disturbed by writes other than suspend or abort
   a_r10_erase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_BUSY_ER && !warm_rst && cnt != '0 && !cmd_susp && !cmd_rst)
      |=> (state == S_BUSY_ER));

   // R11: a suspended erase keeps its remaining time until a write arrives
   a_r11_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_SUSP && !we && !warm_rst) |=> (state == S_SUSP && $stable(cnt)));

   // R9: a program never commits into a sector that was protected when armed
   a_r9_no_prot_prog: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PGM_ARM && we && prot_hit && !warm_rst) |=> (state == S_READ));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
   parameter int ADDR_W       = 12,
   parameter int MAIN_SECTORS = 8,
   parameter int MAIN_BYTE_AW = 4,
   parameter int SEC_SECTORS  = 4,
   parameter int SEC_BYTE_AW  = 3,
   parameter int PROG_CYC     = 8,
   parameter int ERASE_CYC    = 64,
   parameter int WIN_CYC      = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    warm_rst,
   input  logic                    bus_we,
   input  logic                    bus_re,
   input  logic                    bus_bank,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [7:0]              bus_wdata,
   input  logic [MAIN_SECTORS-1:0] wp_main,
   input  logic [SEC_SECTORS-1:0]  wp_sec,
   output logic [7:0]              bus_rdata,
   output logic                    rdy
);
   if (ADDR_W < 12) begin : g_chk_aw
      $error("flash_cmd_ctrl: ADDR_W must cover the 12-bit command offsets");
   end
   if (MAIN_BYTE_AW + $clog2(MAIN_SECTORS) > ADDR_W ||
       SEC_BYTE_AW + $clog2(SEC_SECTORS) > ADDR_W) begin : g_chk_geom
      $error("flash_cmd_ctrl: bank geometry exceeds ADDR_W");
   end

   logic [7:0] rd_bank [2];
   logic [1:0] busy_b;
   logic       rsel_q;

   for (genvar g = 0; g < 2; g++) begin : g_bank
      localparam int SN = (g == 0) ? MAIN_SECTORS : SEC_SECTORS;
      localparam int BA = (g == 0) ? MAIN_BYTE_AW : SEC_BYTE_AW;
      localparam int AW = BA + $clog2(SN);

      logic [SN-1:0] wp_g;
      logic          we_g, re_g, pg_en, er_en;
      logic [AW-1:0] st_addr, pg_addr;
      logic [7:0]    st_rdata, pg_data;
      logic [SN-1:0] er_mask;

      if (g == 0) begin : g_wm
         assign wp_g = wp_main;
      end else begin : g_ws
         assign wp_g = wp_sec;
      end

      assign we_g = bus_we && (bus_bank == 1'(g));
      assign re_g = bus_re && (bus_bank == 1'(g));

      flash_bank_seq #(
         .SECTORS(SN), .BYTE_AW(BA), .ADDR_W(ADDR_W),
         .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC)
      ) i_seq (
         .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
         .we(we_g), .re(re_g), .addr(bus_addr), .wdata(bus_wdata), .wp(wp_g),
         .busy(busy_b[g]), .rdata(rd_bank[g]),
         .st_addr(st_addr), .st_rdata(st_rdata),
         .pg_en(pg_en), .pg_addr(pg_addr), .pg_data(pg_data),
         .er_en(er_en), .er_mask(er_mask)
      );

      flash_store #(.SECTORS(SN), .BYTE_AW(BA)) i_store (
         .clk(clk), .rst_n(rst_n),
         .rd_addr(st_addr), .rd_data(st_rdata),
         .pg_en(pg_en), .pg_addr(pg_addr), .pg_data(pg_data),
         .er_en(er_en), .er_mask(er_mask)
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rsel_q <= 1'b0;
      else if (bus_re) rsel_q <= bus_bank;
   end

   assign bus_rdata = rd_bank[rsel_q];
   assign rdy       = ~|busy_b;

   // R13: read data only moves on a clock that carried a read
   a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
   localparam int PROG  = 8;
   localparam int ERASE = 64;
   localparam int WIN   = 16;

   logic        clk = 1'b0, rst_n = 1'b0, warm_rst = 1'b0;
   logic        bus_we = 1'b0, bus_re = 1'b0, bus_bank = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  wp_main = '0;
   logic [3:0]  wp_sec = '0;
   logic [7:0]  bus_rdata;
   logic        rdy;

   int    n_chk = 0, n_fail = 0, cycles = 0;
   string cur_req = "R13";

   flash_cmd_ctrl i_flash_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
      .bus_we(bus_we), .bus_re(bus_re), .bus_bank(bus_bank),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .wp_main(wp_main), .wp_sec(wp_sec),
      .bus_rdata(bus_rdata), .rdy(rdy)
   );

   always #2 clk = ~clk;

   // ---------------- behavioural reference model ----------------
   int       md  [2];
   int       cnt [2];
   bit [7:0] mm  [2][128];
   bit       msk [2][8];
   bit [7:0] tdat[2];
   int       tadr[2];
   bit       mfail[2];
   bit       mtog[2];
   bit [7:0] exp_rd = 8'h00;
   bit       exp_rdy = 1'b1;

   function automatic int nsec(int b); return (b == 0) ? 8 : 4; endfunction
   function automatic int bwid(int b); return (b == 0) ? 4 : 3; endfunction
   function automatic bit prot(int b, int s);
      return (b == 0) ? wp_main[s] : wp_sec[s[1:0]];
   endfunction
   function automatic bit any_msk(int b);
      for (int s = 0; s < 8; s++) if (msk[b][s]) return 1'b1;
      return 1'b0;
   endfunction
   function automatic void clr_msk(int b);
      for (int s = 0; s < 8; s++) msk[b][s] = 1'b0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < 2; b++) begin
            md[b] = 0; cnt[b] = 0; tdat[b] = 0; tadr[b] = 0; mfail[b] = 0; mtog[b] = 0;
            clr_msk(b);
            for (int i = 0; i < 128; i++) mm[b][i] = 8'hFF;
         end
         exp_rd = 8'h00;
      end else if (warm_rst) begin
         for (int b = 0; b < 2; b++) begin
            md[b] = 0; cnt[b] = 0; mtog[b] = 0; clr_msk(b);
         end
      end else begin
         int b, a, sec, idx;
         bit [7:0] d;
         b = int'(bus_bank); a = int'(bus_addr); d = bus_wdata;
         sec = (a >> bwid(b)) % nsec(b);
         idx = a % (nsec(b) << bwid(b));
         if (bus_re) begin
            if (md[b] == 7 || md[b] == 8 || md[b] == 9 || md[b] == 11 ||
                (md[b] == 10 && msk[b][sec])) begin
               exp_rd = {~tdat[b][7], mtog[b], md[b] == 11, 5'b0};
               mtog[b] = ~mtog[b];
            end else exp_rd = mm[b][idx];
         end
         for (int k = 0; k < 2; k++) begin
            bit w, p;
            w = bus_we && (b == k);
            p = prot(k, sec);
            case (md[k])
               0: if (w && d == 8'hAA && a == 'h555) md[k] = 1;
               1: if (w) md[k] = (d == 8'h55 && a == 'hAAA) ? 2 : 0;
               2: if (w) md[k] = (a == 'h555 && d == 8'hA0) ? 3 :
                                 (a == 'h555 && d == 8'h80) ? 4 : 0;
               3: if (w) begin
                  if (p) md[k] = 0;
                  else begin
                     tadr[k] = idx; tdat[k] = d;
                     mfail[k] = (d & ~mm[k][idx]) != 0;
                     cnt[k] = PROG - 1; md[k] = 8;
                  end
               end
               4: if (w) md[k] = (d == 8'hAA && a == 'h555) ? 5 : 0;
               5: if (w) md[k] = (d == 8'h55 && a == 'hAAA) ? 6 : 0;
               6: if (w) begin
                  if (a == 'h555 && d == 8'h10) begin
                     clr_msk(k);
                     for (int s = 0; s < nsec(k); s++) msk[k][s] = !prot(k, s);
                     if (any_msk(k)) begin md[k] = 9; cnt[k] = ERASE - 1; tdat[k] = 8'hFF; end
                     else md[k] = 0;
                  end else if (d == 8'h30) begin
                     clr_msk(k);
                     if (!p) msk[k][sec] = 1'b1;
                     tdat[k] = 8'hFF; cnt[k] = WIN - 1; md[k] = 7;
                  end else md[k] = 0;
               end
               7: if (w) begin
                  if (d == 8'h30) begin
                     if (!p) msk[k][sec] = 1'b1;
                     cnt[k] = WIN - 1;
                  end else begin md[k] = 0; clr_msk(k); end
               end else if (cnt[k] == 0) begin
                  if (any_msk(k)) begin md[k] = 9; cnt[k] = ERASE - 1; end
                  else md[k] = 0;
               end else cnt[k]--;
               8: if (cnt[k] == 0) begin
                  if (!mfail[k]) mm[k][tadr[k]] = mm[k][tadr[k]] & tdat[k];
                  md[k] = mfail[k] ? 11 : 0;
               end else cnt[k]--;
               9: if (w && d == 8'hB0) md[k] = 10;
                  else if (w && d == 8'hF0) begin md[k] = 0; clr_msk(k); end
                  else if (cnt[k] == 0) begin
                     for (int s = 0; s < nsec(k); s++)
                        if (msk[k][s])
                           for (int j = 0; j < (1 << bwid(k)); j++)
                              mm[k][(s << bwid(k)) + j] = 8'hFF;
                     md[k] = 0; clr_msk(k);
                  end else cnt[k]--;
               10: if (w && d == 8'h30) md[k] = 9;
                   else if (w && d == 8'hF0) begin md[k] = 0; clr_msk(k); end
               11: if (w && d == 8'hF0) md[k] = 0;
               default: md[k] = 0;
            endcase
         end
      end
      exp_rdy = !((md[0] >= 7 && md[0] <= 9) || (md[1] >= 7 && md[1] <= 9));
   end

   // ---------------- per-clock comparison ----------------
   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         n_chk += 2;
         if (rdy !== exp_rdy) begin
            n_fail++;
            $display("FAIL R7 (%s): rdy=%0b expected %0b at cycle %0d", cur_req, rdy, exp_rdy, cycles);
         end
         if (bus_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL R13 (%s): rdata=%02h expected %02h at cycle %0d", cur_req, bus_rdata, exp_rd, cycles);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wr(input bit b, input int a, input int d);
      bus_we = 1'b1; bus_bank = b; bus_addr = 12'(a); bus_wdata = 8'(d);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input bit b, input int a, output logic [7:0] v);
      bus_re = 1'b1; bus_bank = b; bus_addr = 12'(a);
      @(negedge clk);
      bus_re = 1'b0;
      v = bus_rdata;
   endtask

   task automatic unlock(input bit b);
      wr(b, 'h555, 'hAA);
      wr(b, 'hAAA, 'h55);
   endtask

   task automatic pgm(input bit b, input int a, input int d);
      unlock(b);
      wr(b, 'h555, 'hA0);
      wr(b, a, d);
   endtask

   task automatic erase_setup(input bit b);
      unlock(b);
      wr(b, 'h555, 'h80);
      unlock(b);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      wait (cycles > 20000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   // ---------------- test sequence ----------------
   initial begin
      logic [7:0] v, v2;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      cur_req = "R13";
      chk("R13 reset rdy", rdy, 1);
      chk("R13 reset rdata", bus_rdata, 8'h00);
      rd(0, 'h000, v); chk("R13 erased after reset", v, 8'hFF);

      cur_req = "R2";
      pgm(0, 'h010, 'h5A);
      chk("R7 rdy low while programming", rdy, 0);
      cur_req = "R6";
      rd(0, 'h010, v);  chk("R6 first status read", v, 8'h80);
      rd(0, 'h010, v2); chk("R6 toggle bit flips", v2, 8'hC0);
      idle(PROG + 2);
      cur_req = "R2";
      rd(0, 'h010, v); chk("R2 programmed byte", v, 8'h5A);

      cur_req = "R3";
      pgm(0, 'h010, 'hFF);
      idle(PROG + 2);
      chk("R7 rdy high in failed state", rdy, 1);
      rd(0, 'h010, v); chk("R3 error flag in status", v & 8'hA0, 8'h20);
      wr(0, 'h000, 'hF0);
      rd(0, 'h010, v); chk("R3 byte unchanged after failed program", v, 8'h5A);

      cur_req = "R1";
      wr(0, 'h555, 'hAA); wr(0, 'h555, 'h55);
      wr(0, 'h555, 'hA0); wr(0, 'h010, 'h00);
      chk("R1 wrong offset starts nothing", rdy, 1);
      unlock(0); wr(0, 'h555, 'h00); wr(0, 'h010, 'h00);
      wr(0, 'h555, 'hAA); wr(0, 'hAAA, 'h54); wr(0, 'h555, 'hA0); wr(0, 'h010, 'h00);
      rd(0, 'h010, v); chk("R1 aborted sequences leave array", v, 8'h5A);

      cur_req = "R8";
      pgm(1, 'h008, 'h33);
      rd(0, 'h010, v); chk("R8 main readable while secondary busy", v, 8'h5A);
      rd(1, 'h008, v); chk("R8 busy bank returns status", v & 8'hA0, 8'h80);
      pgm(0, 'h030, 'h11);
      idle(PROG + 2);
      rd(1, 'h008, v); chk("R8 secondary programmed", v, 8'h33);
      rd(0, 'h030, v); chk("R8 main command during other bank busy", v, 8'h11);
      pgm(0, 'h000, 'h00); idle(PROG + 2);
      pgm(0, 'h040, 'h22); idle(PROG + 2);
      pgm(0, 'h050, 'h44); idle(PROG + 2);

      cur_req = "R4";
      erase_setup(0);
      wr(0, 'h010, 'h30);
      idle(5);
      wr(0, 'h020, 'h30);
      chk("R7 rdy low in erase window", rdy, 0);
      idle(WIN + ERASE + 10);
      rd(0, 'h010, v); chk("R4 first sector erased", v, 8'hFF);
      rd(0, 'h025, v); chk("R4 added sector erased", v, 8'hFF);
      rd(0, 'h030, v); chk("R4 other sector kept", v, 8'h11);

      cur_req = "R11";
      erase_setup(0);
      wr(0, 'h040, 'h30);
      idle(WIN + 10);
      cur_req = "R10";
      wr(0, 'h050, 'h12);
      chk("R10 ignored write keeps erase busy", rdy, 0);
      cur_req = "R11";
      wr(0, 'h000, 'hB0);
      chk("R11 rdy high while suspended", rdy, 1);
      rd(0, 'h050, v); chk("R11 read outside erase set", v, 8'h44);
      rd(0, 'h040, v); chk("R11 erase set reads status", v & 8'hA0, 8'h00);
      idle(ERASE);
      rd(0, 'h041, v); chk("R11 timer holds while suspended", v & 8'hA0, 8'h00);
      wr(0, 'h000, 'h30);
      chk("R11 resume goes busy", rdy, 0);
      idle(ERASE);
      rd(0, 'h040, v); chk("R11 erase completes after resume", v, 8'hFF);
      rd(0, 'h050, v); chk("R10 ignored write left byte", v, 8'h44);

      cur_req = "R10";
      erase_setup(0);
      wr(0, 'h050, 'h30);
      idle(WIN + 5);
      wr(0, 'h000, 'hF0);
      chk("R10 abort returns ready", rdy, 1);
      rd(0, 'h050, v); chk("R10 abort leaves sector", v, 8'h44);

      cur_req = "R9";
      wp_main = 8'h08;
      pgm(0, 'h031, 'h00);
      chk("R9 protected program not busy", rdy, 1);
      rd(0, 'h031, v); chk("R9 protected byte unchanged", v, 8'hFF);
      erase_setup(0);
      wr(0, 'h030, 'h30);
      idle(WIN + 5);
      chk("R9 empty erase set never starts", rdy, 1);
      rd(0, 'h030, v); chk("R9 protected sector kept", v, 8'h11);

      cur_req = "R5";
      erase_setup(0);
      wr(0, 'h555, 'h10);
      chk("R5 bulk erase busy", rdy, 0);
      idle(ERASE + 5);
      rd(0, 'h000, v); chk("R5 unprotected sector erased", v, 8'hFF);
      rd(0, 'h050, v); chk("R5 second sector erased", v, 8'hFF);
      rd(0, 'h030, v); chk("R9 protected sector survives bulk", v, 8'h11);
      wp_main = 8'h00;

      cur_req = "R12";
      pgm(1, 'h010, 'h00);
      idle(3);
      warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
      chk("R12 ready after warm reset", rdy, 1);
      rd(1, 'h010, v); chk("R12 aborted program", v, 8'hFF);

      cur_req = "R5";
      erase_setup(1);
      wr(1, 'h555, 'h10);
      idle(ERASE + 5);
      rd(1, 'h008, v); chk("R5 secondary bulk erase", v, 8'hFF);
      rd(0, 'h030, v); chk("R8 main untouched by secondary erase", v, 8'h11);

      idle(4);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule